// File: doc/BRIEF.md
# Scalar Float Compare Predicate Unit

This unit compares the low 32-bit lanes of two 128-bit source vectors as IEEE-754 single-precision values. A 5-bit predicate code selects the test. The code combines a relation (equal, less, greater and their negations, ordered, unordered, constant false or true) with a rule for NaN operands and with a quiet or signaling attribute. Besides the boolean outcome, the unit reports an invalid-operation flag and a denormal-operand flag.

The same comparison is written back in one of three formats. The two vector formats place an all-ones or all-zeros 32-bit mask in the low lane. The legacy vector format fills the upper lanes from the old destination value. The merging vector format fills them from the first source. The mask-register format produces a single result bit gated by a zeroing writemask. The unit is one registered stage: a request accepted with its valid strobe produces results one clock later, and the outputs hold between requests.

Top module: `fcmp_unit`

## Requirements
- R1: A request with `req_vld_i` high at a rising edge sets `res_vld_o` and all result outputs after that edge. With `req_vld_i` low, `res_vld_o` is low at the next edge and every result output keeps its value. Reset clears all outputs to zero.
- R2: `fmt_i` = 2'b00 is the legacy vector format, 2'b01 is the merging vector format, and 2'b10 or 2'b11 is the mask-register format. The legacy format takes the predicate code from `imm_i[2:0]`, with the two upper code bits zero. The other formats take it from `imm_i[4:0]`. All remaining immediate bits have no effect.
- R3: Call the operands unordered when either is a NaN. In that case equal, less and greater are all false. For code bits [3:0], the result is: 0 eq, 1 lt, 2 lt|eq, 3 unordered, 4 !eq, 5 !lt, 6 !(lt|eq), 7 ordered, 8 eq|unordered, 9 !(gt|eq), 10 !gt, 11 false, 12 ordered&!eq, 13 gt|eq, 14 gt, 15 true.
- R4: Codes 16 to 31 give the same result as the code 16 below them. A code is signaling when bit0 XOR bit1 XOR bit4 is 1.
- R5: +0 and -0 compare equal. Other values are ordered by sign, then by the magnitude in bits 30:0, with the order reversed for two negative values.
- R6: `invalid_o` is set when either operand is a signaling NaN (exponent all ones, fraction bit 22 clear, fraction nonzero). It is also set when either operand is a quiet NaN (bit 22 set) and the code is signaling.
- R7: `denorm_o` is set when either operand has a zero exponent and a nonzero fraction.
- R8: In both vector formats, `vec_o[31:0]` is 32'hFFFFFFFF for a true result and 32'h0 for a false result, and `kmask_o` is zero.
- R9: In the legacy format, `vec_o[127:32]` equals `dst_i[127:32]`.
- R10: In the merging format, `vec_o[127:32]` equals `src_a_i[127:32]`.
- R11: In the mask-register format, `kmask_o[0]` is the result when `wmask_bit_i` is 1 or `wmask_en_i` is 0, and 0 otherwise. `kmask_o[7:1]` and `vec_o` are zero. `cmp_o` always carries the unmasked result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_vld_i | input | 1 | Request strobe |
| src_a_i | input | 128 | First source vector; low lane is the left operand |
| src_b_i | input | 128 | Second source vector; low lane is the right operand |
| dst_i | input | 128 | Old destination contents for the legacy format |
| imm_i | input | 8 | Immediate holding the predicate code |
| fmt_i | input | 2 | Writeback format select |
| wmask_bit_i | input | 1 | Writemask bit for the mask-register format |
| wmask_en_i | input | 1 | Writemask in use |
| res_vld_o | output | 1 | Result valid, one cycle after the request |
| cmp_o | output | 1 | Unmasked comparison result |
| invalid_o | output | 1 | Invalid-operation flag |
| denorm_o | output | 1 | Denormal-operand flag |
| vec_o | output | 128 | Vector-format writeback value |
| kmask_o | output | 8 | Mask-register writeback value |

## Verification
The bench builds the unit with its default parameters: 128-bit vectors, 32-bit lanes with an 8-bit exponent, and an 8-bit mask register. With these values, real single-precision encodings can be applied directly to the operands. Infinities, signed zeros, the smallest denormal, and quiet and signaling NaNs therefore reach every relation. The 96 upper vector bits are wide enough to tell the old destination apart from the first source in the two merge styles. The mask register has seven upper bits whose clearing can be observed.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;

    typedef enum logic [1:0] {
        FMT_LEGACY = 2'b00,
        FMT_MERGE  = 2'b01,
        FMT_KMASK  = 2'b10
    } fmt_e;

    typedef struct packed {
        logic nan;
        logic snan;
        logic qnan;
        logic zero;
        logic denorm;
    } fp_class_t;

    typedef struct packed {
        logic unord;
        logic eq;
        logic lt;
        logic gt;
    } rel_t;

endpackage

// File: rtl/fcmp_classify.sv
module fcmp_classify
    import fcmp_pkg::*;
#(
    parameter int LANE_W = 32,
    parameter int EXP_W  = 8
) (
    input  logic [LANE_W-1:0] op_i,
    output fp_class_t         cls_o
);
    localparam int MAN_W = LANE_W - 1 - EXP_W;

    logic [EXP_W-1:0] exp_f;
    logic [MAN_W-1:0] man_f;
    logic             exp_ones;
    logic             exp_zero;
    logic             man_nz;

    always_comb begin
        exp_f    = op_i[LANE_W-2 -: EXP_W];
        man_f    = op_i[MAN_W-1:0];
        exp_ones = &exp_f;
        exp_zero = ~|exp_f;
        man_nz   = |man_f;
        cls_o.nan    = exp_ones & man_nz;
        cls_o.qnan   = exp_ones & man_f[MAN_W-1];
        cls_o.snan   = exp_ones & man_nz & ~man_f[MAN_W-1];
        cls_o.zero   = exp_zero & ~man_nz;
        cls_o.denorm = exp_zero & man_nz;
    end

endmodule

// File: rtl/fcmp_relation.sv
module fcmp_relation
    import fcmp_pkg::*;
#(
    parameter int LANE_W = 32
) (
    input  logic [LANE_W-1:0] a_i,
    input  logic [LANE_W-1:0] b_i,
    input  fp_class_t         cls_a_i,
    input  fp_class_t         cls_b_i,
    output rel_t              rel_o
);
    logic              sgn_a;
    logic              sgn_b;
    logic [LANE_W-2:0] mag_a;
    logic [LANE_W-2:0] mag_b;

    always_comb begin
        sgn_a = a_i[LANE_W-1];
        sgn_b = b_i[LANE_W-1];
        mag_a = a_i[LANE_W-2:0];
        mag_b = b_i[LANE_W-2:0];
        rel_o = '0;
        rel_o.unord = cls_a_i.nan | cls_b_i.nan;
        if (!rel_o.unord) begin
            if (cls_a_i.zero && cls_b_i.zero) begin
                rel_o.eq = 1'b1;
            end else if (a_i == b_i) begin
                rel_o.eq = 1'b1;
            end else if (sgn_a != sgn_b) begin
                rel_o.lt = sgn_a;
            end else if (!sgn_a) begin
                rel_o.lt = mag_a < mag_b;
            end else begin
                rel_o.lt = mag_a > mag_b;
            end
            rel_o.gt = ~rel_o.eq & ~rel_o.lt;
        end
    end

endmodule

// File: rtl/fcmp_predicate.sv
module fcmp_predicate
    import fcmp_pkg::*;
#(
    parameter int CODE_W = 5
) (
    input  logic [CODE_W-1:0] code_i,
    input  rel_t              rel_i,
    output logic              hit_o,
    output logic              sig_o
);
    logic ord;

    always_comb begin
        ord   = ~rel_i.unord;
        sig_o = code_i[0] ^ code_i[1] ^ code_i[4];
        unique case (code_i[3:0])
            4'd0:  hit_o = rel_i.eq;
            4'd1:  hit_o = rel_i.lt;
            4'd2:  hit_o = rel_i.lt | rel_i.eq;
            4'd3:  hit_o = rel_i.unord;
            4'd4:  hit_o = ~rel_i.eq;
            4'd5:  hit_o = ~rel_i.lt;
            4'd6:  hit_o = ~(rel_i.lt | rel_i.eq);
            4'd7:  hit_o = ord;
            4'd8:  hit_o = rel_i.eq | rel_i.unord;
            4'd9:  hit_o = ~(rel_i.gt | rel_i.eq);
            4'd10: hit_o = ~rel_i.gt;
            4'd11: hit_o = 1'b0;
            4'd12: hit_o = ord & ~rel_i.eq;
            4'd13: hit_o = rel_i.gt | rel_i.eq;
            4'd14: hit_o = rel_i.gt;
            default: hit_o = 1'b1;
        endcase
    end

endmodule

// File: rtl/fcmp_unit.sv
module fcmp_unit
    import fcmp_pkg::*;
#(
    parameter int VEC_W   = 128,
    parameter int LANE_W  = 32,
    parameter int EXP_W   = 8,
    parameter int KMASK_W = 8,
    parameter int IMM_W   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_vld_i,
    input  logic [VEC_W-1:0]   src_a_i,
    input  logic [VEC_W-1:0]   src_b_i,
    input  logic [VEC_W-1:0]   dst_i,
    input  logic [IMM_W-1:0]   imm_i,
    input  logic [1:0]         fmt_i,
    input  logic               wmask_bit_i,
    input  logic               wmask_en_i,
    output logic               res_vld_o,
    output logic               cmp_o,
    output logic               invalid_o,
    output logic               denorm_o,
    output logic [VEC_W-1:0]   vec_o,
    output logic [KMASK_W-1:0] kmask_o
);
    localparam int CODE_W   = 5;
    localparam int LEGACY_W = 3;
    localparam int UPPER_W  = VEC_W - LANE_W;
    localparam int MAN_W    = LANE_W - 1 - EXP_W;

    typedef struct packed {
        logic               vld;
        logic               cmp;
        logic               inv;
        logic               den;
        logic [VEC_W-1:0]   vec;
        logic [KMASK_W-1:0] kmask;
    } state_t;

    state_t st_d, st_q;

    fp_class_t          cls_a, cls_b;
    rel_t               rel;
    logic [CODE_W-1:0]  code;
    logic               hit;
    logic               sig;

    fcmp_classify #(.LANE_W(LANE_W), .EXP_W(EXP_W)) u_cls_a (
        .op_i (src_a_i[LANE_W-1:0]),
        .cls_o(cls_a)
    );

    fcmp_classify #(.LANE_W(LANE_W), .EXP_W(EXP_W)) u_cls_b (
        .op_i (src_b_i[LANE_W-1:0]),
        .cls_o(cls_b)
    );

    fcmp_relation #(.LANE_W(LANE_W)) u_rel (
        .a_i    (src_a_i[LANE_W-1:0]),
        .b_i    (src_b_i[LANE_W-1:0]),
        .cls_a_i(cls_a),
        .cls_b_i(cls_b),
        .rel_o  (rel)
    );

    always_comb begin
        if (fmt_i == FMT_LEGACY) begin
            code = {{(CODE_W-LEGACY_W){1'b0}}, imm_i[LEGACY_W-1:0]};
        end else begin
            code = imm_i[CODE_W-1:0];
        end
    end

    fcmp_predicate #(.CODE_W(CODE_W)) u_pred (
        .code_i(code),
        .rel_i (rel),
        .hit_o (hit),
        .sig_o (sig)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = req_vld_i;
        if (req_vld_i) begin
            st_d.cmp   = hit;
            st_d.inv   = cls_a.snan | cls_b.snan | ((cls_a.qnan | cls_b.qnan) & sig);
            st_d.den   = cls_a.denorm | cls_b.denorm;
            st_d.vec   = '0;
            st_d.kmask = '0;
            if (fmt_i[1]) begin
                st_d.kmask[0] = hit & (wmask_bit_i | ~wmask_en_i);
            end else if (fmt_i[0]) begin
                st_d.vec = {src_a_i[VEC_W-1:LANE_W], {LANE_W{hit}}};
            end else begin
                st_d.vec = {dst_i[VEC_W-1:LANE_W], {LANE_W{hit}}};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign res_vld_o = st_q.vld;
    assign cmp_o     = st_q.cmp;
    assign invalid_o = st_q.inv;
    assign denorm_o  = st_q.den;
    assign vec_o     = st_q.vec;
    assign kmask_o   = st_q.kmask;

    // Signaling-NaN detection written from the format, for the R6 check
    function automatic logic is_snan(input logic [LANE_W-1:0] v);
        return (&v[LANE_W-2 -: EXP_W]) && !v[MAN_W-1] && (|v[MAN_W-2:0]);
    endfunction

    a_r1_result_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_vld_i |=> res_vld_o);

    a_r1_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !req_vld_i |=> (!res_vld_o && $stable({cmp_o, invalid_o, denorm_o, vec_o, kmask_o})));

    a_r6_snan_invalid: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld_i && (is_snan(src_a_i[LANE_W-1:0]) || is_snan(src_b_i[LANE_W-1:0]))) |=> invalid_o);

    a_r8_lane_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld_i && !fmt_i[1]) |=> (vec_o[LANE_W-1:0] == {LANE_W{cmp_o}} && kmask_o == '0));

    a_r9_legacy_upper: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld_i && fmt_i == FMT_LEGACY) |=> (vec_o[VEC_W-1:LANE_W] == $past(dst_i[VEC_W-1:LANE_W])));

    a_r10_merge_upper: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld_i && fmt_i == FMT_MERGE) |=> (vec_o[VEC_W-1:LANE_W] == $past(src_a_i[VEC_W-1:LANE_W])));

    a_r11_zero_masking: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld_i && fmt_i[1] && wmask_en_i && !wmask_bit_i) |=> (kmask_o == '0 && vec_o == '0));

    a_r11_high_bits_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld_i && fmt_i[1]) |=> (kmask_o[KMASK_W-1:1] == '0 && kmask_o[0] == (cmp_o & $past(wmask_bit_i | !wmask_en_i))));

    logic [UPPER_W-1:0] unused_upper_b;
    assign unused_upper_b = src_b_i[VEC_W-1:LANE_W];

endmodule

// File: tb/fcmp_unit_tb.sv
module fcmp_unit_tb;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         req_vld_i;
    logic [127:0] src_a_i, src_b_i, dst_i;
    logic [7:0]   imm_i;
    logic [1:0]   fmt_i;
    logic         wmask_bit_i, wmask_en_i;
    logic         res_vld_o, cmp_o, invalid_o, denorm_o;
    logic [127:0] vec_o;
    logic [7:0]   kmask_o;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    fcmp_unit u_dut (
        .clk(clk), .rst_n(rst_n), .req_vld_i(req_vld_i),
        .src_a_i(src_a_i), .src_b_i(src_b_i), .dst_i(dst_i),
        .imm_i(imm_i), .fmt_i(fmt_i),
        .wmask_bit_i(wmask_bit_i), .wmask_en_i(wmask_en_i),
        .res_vld_o(res_vld_o), .cmp_o(cmp_o), .invalid_o(invalid_o),
        .denorm_o(denorm_o), .vec_o(vec_o), .kmask_o(kmask_o)
    );

    localparam logic [31:0] P1 = 32'h3F800000, P2 = 32'h40000000;
    localparam logic [31:0] N1 = 32'hBF800000, N2 = 32'hC0000000;
    localparam logic [31:0] PZ = 32'h00000000, NZ = 32'h80000000;
    localparam logic [31:0] QN = 32'h7FC00000, SN = 32'h7F800001;
    localparam logic [31:0] PI = 32'h7F800000, NI = 32'hFF800000;
    localparam logic [31:0] DN = 32'h00000001;

    localparam logic [95:0] UP_A = 96'hAAAA_0001_AAAA_0002_AAAA_0003;
    localparam logic [95:0] UP_B = 96'hBBBB_0001_BBBB_0002_BBBB_0003;
    localparam logic [95:0] UP_D = 96'hDDDD_0001_DDDD_0002_DDDD_0003;

    // {a, b, code, expected cmp, expected invalid, expected denormal}
    localparam int NV = 27;
    localparam logic [71:0] VECS [NV] = '{
        {P1, P2,  5'd1, 3'b100},  // R3 lt true
        {P2, P1,  5'd1, 3'b000},  // R3 lt false
        {P1, P1,  5'd0, 3'b100},  // R3 eq
        {PZ, NZ,  5'd0, 3'b100},  // R5 signed zeros equal
        {N1, P1,  5'd1, 3'b100},  // R5 sign order
        {N1, N2, 5'd14, 3'b100},  // R5 negative magnitudes reversed
        {QN, P1,  5'd0, 3'b000},  // R3 eq ordered with NaN
        {QN, P1,  5'd4, 3'b100},  // R3 neq unordered
        {QN, P1,  5'd1, 3'b010},  // R6 qnan with signaling code
        {QN, P1, 5'd17, 3'b000},  // R4 quiet twin of lt
        {SN, P1,  5'd0, 3'b010},  // R6 snan always invalid
        {QN, P1,  5'd3, 3'b100},  // R3 unordered
        {P1, QN,  5'd7, 3'b000},  // R3 ordered
        {P1, P2, 5'd11, 3'b000},  // R3 false
        {P1, P2, 5'd15, 3'b100},  // R3 true
        {P2, P2, 5'd13, 3'b100},  // R3 ge
        {P1, P2,  5'd9, 3'b100},  // R3 nge
        {QN, QN,  5'd8, 3'b100},  // R3 eq or unordered
        {P1, P2, 5'd12, 3'b100},  // R3 neq ordered
        {P1, P2,  5'd6, 3'b000},  // R3 nle
        {PI, P1, 5'd14, 3'b100},  // R3 gt infinity
        {NI, N1,  5'd1, 3'b100},  // R5 -inf below -1
        {QN, P1, 5'd16, 3'b010},  // R4 signaling twin of eq
        {P1, P2, 5'd31, 3'b100},  // R4 true, signaling
        {QN, P1, 5'd27, 3'b010},  // R4 false, signaling
        {P1, P1,  5'd5, 3'b100},  // R3 nlt
        {DN, PZ, 5'd14, 3'b101}   // R7 denormal above zero
    };

    task automatic check(input logic ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // drive on a falling edge, let one rising edge pass, sample on the next falling edge
    task automatic issue(input logic [127:0] a, input logic [127:0] b, input logic [7:0] imm,
                         input logic [1:0] fmt, input logic wb, input logic we);
        src_a_i = a; src_b_i = b; imm_i = imm; fmt_i = fmt;
        wmask_bit_i = wb; wmask_en_i = we; req_vld_i = 1'b1;
        @(negedge clk);
        req_vld_i = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; req_vld_i = 1'b0;
        src_a_i = '0; src_b_i = '0; dst_i = {UP_D, 32'h0};
        imm_i = '0; fmt_i = 2'b01; wmask_bit_i = 1'b0; wmask_en_i = 1'b0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check({res_vld_o, cmp_o, invalid_o, denorm_o, vec_o, kmask_o} == '0, "R1 reset",
              {res_vld_o, cmp_o, invalid_o, denorm_o, vec_o[31:0], kmask_o}, '0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            issue({UP_A, VECS[i][71:40]}, {UP_B, VECS[i][39:8]}, {3'b000, VECS[i][7:3]}, 2'b01, 1'b0, 1'b0);
            check(res_vld_o == 1'b1, "R1 valid", res_vld_o, 1);
            check(cmp_o == VECS[i][2], "R3/R4/R5 result", cmp_o, VECS[i][2]);
            check(invalid_o == VECS[i][1], "R6 invalid", invalid_o, VECS[i][1]);
            check(denorm_o == VECS[i][0], "R7 denormal", denorm_o, VECS[i][0]);
            check(vec_o == {UP_A, {32{VECS[i][2]}}}, "R8/R10 merge vector", vec_o, {UP_A, {32{VECS[i][2]}}});
        end

        // R2 legacy: imm 0xE8 gives code 0 -> quiet eq with NaN false, not invalid
        issue({UP_A, QN}, {UP_B, P1}, 8'hE8, 2'b00, 1'b0, 1'b0);
        check(cmp_o == 1'b0 && invalid_o == 1'b0, "R2 legacy code bits", {cmp_o, invalid_o}, 2'b00);
        check(vec_o == {UP_D, 32'h0}, "R9 legacy upper from dst", vec_o, {UP_D, 32'h0});
        // R2 extended: 0xE8 gives code 8 -> eq or unordered true
        issue({UP_A, QN}, {UP_B, P1}, 8'hE8, 2'b01, 1'b0, 1'b0);
        check(cmp_o == 1'b1 && invalid_o == 1'b0, "R2 extended code bits", {cmp_o, invalid_o}, 2'b10);
        // R2 extended: 0xF0 gives code 16, signaling -> invalid
        issue({UP_A, QN}, {UP_B, P1}, 8'hF0, 2'b01, 1'b0, 1'b0);
        check(invalid_o == 1'b1, "R2 bits 7:5 ignored", invalid_o, 1);
        // R9 true result in legacy
        issue({UP_A, P1}, {UP_B, P2}, 8'hF9, 2'b00, 1'b0, 1'b0);
        check(vec_o == {UP_D, 32'hFFFFFFFF}, "R9 legacy true mask", vec_o, {UP_D, 32'hFFFFFFFF});
        check(kmask_o == 8'h00, "R8 kmask zero in vector format", kmask_o, 0);

        // R11 mask-register format
        issue({UP_A, P1}, {UP_B, P2}, 8'h01, 2'b10, 1'b0, 1'b1);
        check(kmask_o == 8'h00 && cmp_o == 1'b1, "R11 zeroing writemask", {cmp_o, kmask_o}, {1'b1, 8'h00});
        check(vec_o == '0, "R11 vector zero", vec_o, 0);
        issue({UP_A, P1}, {UP_B, P2}, 8'h01, 2'b10, 1'b1, 1'b1);
        check(kmask_o == 8'h01, "R11 writemask set", kmask_o, 1);
        issue({UP_A, P1}, {UP_B, P2}, 8'h01, 2'b11, 1'b0, 1'b0);
        check(kmask_o == 8'h01, "R11 no writemask", kmask_o, 1);
        issue({UP_A, P2}, {UP_B, P1}, 8'h01, 2'b10, 1'b1, 1'b1);
        check(kmask_o == 8'h00, "R11 false result", kmask_o, 0);

        // R1 hold: inputs change without a request
        issue({UP_A, P1}, {UP_B, P2}, 8'h01, 2'b01, 1'b0, 1'b0);
        src_a_i = {UP_B, SN}; src_b_i = {UP_A, DN}; imm_i = 8'h0B; fmt_i = 2'b10;
        @(negedge clk);
        check(res_vld_o == 1'b0, "R1 valid drops", res_vld_o, 0);
        check(cmp_o == 1'b1 && invalid_o == 1'b0 && denorm_o == 1'b0, "R1 flags held",
              {cmp_o, invalid_o, denorm_o}, 3'b100);
        check(vec_o == {UP_A, 32'hFFFFFFFF}, "R1 vector held", vec_o, {UP_A, 32'hFFFFFFFF});

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule